// File: doc/BRIEF.md
# Dual-Mode Pipeline Converter Digital Back-End

This block sits behind a ring of NSTG identical pipeline stages that resolve 1.5 bits each. Every clock, each stage hands over a 2-bit comparator code. A single select input chooses how those codes are used, and the select may be flipped at any time while the block runs.

In convert mode the codes are redundant signed digits. The block delays each stage's code so that all codes of one analog sample line up, then adds them with binary weights into a signed two's-complement result of NSTG+1 bits. In generate mode the two bits of each stage are combined by exclusive-or into one raw random bit. Each group of four neighbouring raw bits is reduced to its parity. The parity chunks are packed over four clocks into one NSTG-bit random word. Both paths drive one shared registered output bus with a valid strobe. A sticky flag records any stage code outside the legal set.

Top module: `dm_backend`

## Requirements
- R1: While rst_n is low and after its release, before any new result is ready, out_valid is 0, out_data is 0, code_err is 0, and the mode in force is convert.
- R2: Stage i drives stage_codes[2i+1:2i]. Field value 2'b00 is digit -1, 2'b01 is digit 0 and 2'b11 is digit +1. Stage i carries weight 2^(NSTG-1-i), so stage 0 is the most significant.
- R3: Stage i presents its code for sample s i clocks after stage 0 does. The signed sum of the digits of sample s, in NSTG+1 bits two's complement, appears on out_data NSTG+1 clocks after stage 0's code was sampled.
- R4: In convert mode (gen_sel=0), out_valid is 1 after an edge exactly when gen_sel was 0 at that edge and at each of the NSTG+1 edges before it.
- R5: In generate mode (gen_sel=1), the raw bit of each stage is the XOR of its two code bits. Bit g of each clock's chunk is the parity of the raw bits of stages 4g to 4g+3.
- R6: A random word is built from 4 consecutive chunks, with the oldest chunk in the highest bits. It is shown on out_data[NSTG-1:0] with out_data[NSTG] driven to 0.
- R7: In generate mode, out_valid is 1 for one clock on the 4th, 8th, 12th, ... consecutive edge with gen_sel=1. A partial word is dropped when gen_sel returns to 0.
- R8: The illegal field value 2'b10 is handled as 2'b01 by both paths: digit 0 in convert mode and raw bit 1 in generate mode.
- R9: code_err becomes 1 after the first edge that samples a 2'b10 field on any stage, in either mode, and stays 1 until reset.
- R10: While out_valid is 0, out_data keeps its last value.
- R11: When gen_sel at an edge differs from its value at the previous edge, out_valid is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_sel | input | 1 | 0 selects convert, 1 selects generate |
| stage_codes | input | 2*NSTG | Per-stage comparator codes, stage i in bits [2i+1:2i] |
| out_data | output | NSTG+1 | Shared result bus: signed sample or random word |
| out_valid | output | 1 | Result on out_data is new this clock |
| code_err | output | 1 | Sticky illegal-code flag |

## Verification
The hardest case to reach is a mode change that lands while a convert sample is only partly through the alignment chains, or while a random word is only partly packed. A bounce back after one to three clocks is the worst case, because leftover state from the old mode could then leak into a strobe. The stimulus uses segments of random length between mode flips, and about a quarter of them are very short, so every refill and discard boundary is hit many times. Directed runs with all-positive and all-negative digits reach the extremes of the sum. A late phase then injects illegal codes in both modes.

// File: rtl/bk_pkg.sv
`timescale 1ns/1ps
package bk_pkg;

  typedef enum logic {
    MODE_CONV = 1'b0,
    MODE_GEN  = 1'b1
  } mode_e;

  localparam logic [1:0] CODE_NEG  = 2'b00;
  localparam logic [1:0] CODE_ZERO = 2'b01;
  localparam logic [1:0] CODE_BAD  = 2'b10;
  localparam logic [1:0] CODE_POS  = 2'b11;

  // Illegal code is folded onto the zero digit (R8)
  function automatic logic [1:0] fix_code(input logic [1:0] c);
    return (c == CODE_BAD) ? CODE_ZERO : c;
  endfunction

  // Signed digit of a stage code (R2)
  function automatic logic signed [1:0] code_digit(input logic [1:0] c);
    logic [1:0] f;
    f = fix_code(c);
    case (f)
      CODE_NEG: return -2'sd1;
      CODE_POS: return 2'sd1;
      default:  return 2'sd0;
    endcase
  endfunction

  // Raw random bit of a stage code (R5)
  function automatic logic raw_bit(input logic [1:0] c);
    logic [1:0] f;
    f = fix_code(c);
    return f[0] ^ f[1];
  endfunction

  function automatic logic is_bad(input logic [1:0] c);
    return c == CODE_BAD;
  endfunction

endpackage

// File: rtl/bk_rsd_corr.sv
`timescale 1ns/1ps
module bk_rsd_corr
  import bk_pkg::*;
#(
  parameter int NSTG = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*NSTG-1:0]    codes,
  output logic [NSTG:0]        sum
);
  localparam int OUT_W = NSTG + 1;

  logic [NSTG-1:0][1:0] aligned;

  // Stage i is delayed by NSTG+1-i clocks, so every stage lands on the
  // same edge for one sample and the adder output is registered once more
  // in the output selector: NSTG+1 clocks from stage 0 to the bus (R3).
  for (genvar i = 0; i < NSTG; i++) begin : g_chain
    localparam int D = NSTG + 1 - i;
    logic [D-1:0][1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chain <= {D{CODE_ZERO}};
      end else begin
        chain <= {chain[D-2:0], fix_code(codes[2*i +: 2])};
      end
    end
    assign aligned[i] = chain[D-1];
  end

  function automatic logic signed [OUT_W-1:0] weigh(input logic [1:0] c, input int sh);
    logic signed [1:0]       d;
    logic signed [OUT_W-1:0] ext;
    d   = code_digit(c);
    ext = {{(OUT_W-2){d[1]}}, d};
    return ext <<< sh;
  endfunction

  logic signed [OUT_W-1:0] acc;
  always_comb begin
    acc = '0;
    for (int i = 0; i < NSTG; i++) begin
      acc = acc + weigh(aligned[i], NSTG - 1 - i);
    end
  end
  assign sum = acc;

endmodule

// File: rtl/bk_rng_post.sv
`timescale 1ns/1ps
module bk_rng_post
  import bk_pkg::*;
#(
  parameter int NSTG = 8,
  parameter int GRP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_on,
  input  logic [2*NSTG-1:0] codes,
  output logic [NSTG-1:0]   word,
  output logic              word_done
);
  localparam int CHUNK = NSTG / GRP;
  localparam int CW    = (GRP > 2) ? $clog2(GRP) : 1;
  localparam int KEEP  = NSTG - CHUNK;
  localparam logic [CW-1:0] LAST = CW'(GRP - 1);

  logic [NSTG-1:0]  raw;
  logic [CHUNK-1:0] par;
  logic [KEEP-1:0]  shreg;
  logic [CW-1:0]    cnt;
  logic [NSTG-1:0]  word_next;

  for (genvar i = 0; i < NSTG; i++) begin : g_raw
    assign raw[i] = raw_bit(codes[2*i +: 2]);
  end

  // One parity bit per group of GRP neighbouring stages (R5)
  for (genvar g = 0; g < CHUNK; g++) begin : g_par
    assign par[g] = ^raw[g*GRP +: GRP];
  end

  assign word_next = {shreg, par};
  assign word      = word_next;
  assign word_done = gen_on && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !gen_on) begin
      shreg <= '0;
      cnt   <= '0;
    end else begin
      shreg <= word_next[KEEP-1:0];
      cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done);

endmodule

// File: rtl/bk_out_sel.sv
`timescale 1ns/1ps
module bk_out_sel #(
  parameter int NSTG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_now,
  input  logic [NSTG:0]     conv_sum,
  input  logic              conv_ok,
  input  logic [NSTG-1:0]   rng_word,
  input  logic              rng_done,
  output logic [NSTG:0]     out_data,
  output logic              out_valid,
  output logic              out_gen
);
  logic          take;
  logic [NSTG:0] pick;

  assign take = gen_now ? rng_done : conv_ok;
  assign pick = gen_now ? {1'b0, rng_word} : conv_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_gen   <= 1'b0;
    end else begin
      out_valid <= take;
      out_gen   <= gen_now;
      if (take) out_data <= pick;
    end
  end

  a_r6_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_gen) |-> (out_data[NSTG] == 1'b0));

  // Sum of NSTG unit digits never reaches the most negative code (R3)
  a_r3_no_min: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_gen) |-> (out_data != {1'b1, {NSTG{1'b0}}}));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(out_data));

endmodule

// File: rtl/dm_backend.sv
`timescale 1ns/1ps
module dm_backend
  import bk_pkg::*;
#(
  parameter int NSTG = 8,
  parameter int GRP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_sel,
  input  logic [2*NSTG-1:0] stage_codes,
  output logic [NSTG:0]     out_data,
  output logic              out_valid,
  output logic              code_err
);
  localparam int RUN_MAX = NSTG + 2;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic [RUN_W-1:0] FULL = RUN_W'(RUN_MAX);

  mode_e            mode;
  logic             gen_now;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_n;
  logic             conv_ok;
  logic             bad_any;
  logic             err_q;
  logic [NSTG:0]    conv_sum;
  logic [NSTG-1:0]  rng_word;
  logic             rng_done;
  logic             out_gen;

  assign mode    = mode_e'(gen_sel);
  assign gen_now = (mode == MODE_GEN);

  // Count of consecutive convert edges, this edge included (R4)
  assign run_n   = gen_now ? '0 : ((run_q == FULL) ? FULL : run_q + 1'b1);
  assign conv_ok = !gen_now && (run_n == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_n;
  end

  always_comb begin
    bad_any = 1'b0;
    for (int i = 0; i < NSTG; i++) begin
      bad_any = bad_any | is_bad(stage_codes[2*i +: 2]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | bad_any;
  end
  assign code_err = err_q;

  bk_rsd_corr #(.NSTG(NSTG)) u_corr (
    .clk   (clk),
    .rst_n (rst_n),
    .codes (stage_codes),
    .sum   (conv_sum)
  );

  bk_rng_post #(.NSTG(NSTG), .GRP(GRP)) u_rng (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_on    (gen_now),
    .codes     (stage_codes),
    .word      (rng_word),
    .word_done (rng_done)
  );

  bk_out_sel #(.NSTG(NSTG)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_now   (gen_now),
    .conv_sum  (conv_sum),
    .conv_ok   (conv_ok),
    .rng_word  (rng_word),
    .rng_done  (rng_done),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_gen   (out_gen)
  );

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |=> code_err);

  a_r11_switch_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gen_sel) |=> !out_valid);

  a_r4_conv_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_gen) |-> !$past(gen_sel));

endmodule

// File: tb/dm_backend_tb.sv
`timescale 1ns/1ps
module dm_backend_tb;
  localparam int K    = 8;
  localparam int G    = 4;
  localparam int CH   = K / G;
  localparam int HMAX = 4096;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            gen_sel;
  logic [2*K-1:0]  stage_codes;
  logic [K:0]      out_data;
  logic            out_valid;
  logic            code_err;

  always #10 clk = ~clk;

  dm_backend #(.NSTG(K), .GRP(G)) u_dut (
    .clk(clk), .rst_n(rst_n), .gen_sel(gen_sel), .stage_codes(stage_codes),
    .out_data(out_data), .out_valid(out_valid), .code_err(code_err)
  );

  int checks = 0;
  int errors = 0;
  int ec = 0;
  int conv_run = 0;
  int gen_run = 0;
  logic           hist_mode [HMAX];
  logic [2*K-1:0] hist_code [HMAX];
  logic           exp_valid = 1'b0;
  logic [K:0]     exp_data = '0;
  logic           exp_err = 1'b0;
  string          ph = "R3";

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (edge %0d)", tag, act, exp, ec);
    end
  endtask

  function automatic logic [1:0] fld(input int e, input int i);
    return hist_code[e][2*i +: 2];
  endfunction

  // Sum as positive weights minus negative weights
  function automatic logic [K:0] conv_expect(input int e);
    int s, pos, neg;
    s = e - K - 1; pos = 0; neg = 0;
    for (int i = 0; i < K; i++) begin
      if (fld(s + i, i) == 2'b11) pos += (1 << (K - 1 - i));
      else if (fld(s + i, i) == 2'b00) neg += (1 << (K - 1 - i));
    end
    return (K+1)'(pos - neg);
  endfunction

  function automatic logic conv_bad(input int e);
    logic b;
    b = 1'b0;
    for (int i = 0; i < K; i++) if (fld(e - K - 1 + i, i) == 2'b10) b = 1'b1;
    return b;
  endfunction

  function automatic logic [K:0] gen_expect(input int e);
    logic [K:0] w;
    int ones;
    w = '0;
    for (int age = 0; age < G; age++) begin
      for (int g = 0; g < CH; g++) begin
        ones = 0;
        for (int b = 0; b < G; b++) begin
          if (fld(e - age, g*G + b) == 2'b01 || fld(e - age, g*G + b) == 2'b10) ones++;
        end
        w[age*CH + g] = (ones % 2 == 1);
      end
    end
    return w;
  endfunction

  function automatic logic gen_bad(input int e);
    logic b;
    b = 1'b0;
    for (int age = 0; age < G; age++)
      for (int i = 0; i < K; i++) if (fld(e - age, i) == 2'b10) b = 1'b1;
    return b;
  endfunction

  function automatic logic [2*K-1:0] rand_codes(input int bad_pct);
    logic [2*K-1:0] v;
    int r;
    for (int i = 0; i < K; i++) begin
      r = $urandom % 100;
      if (r < bad_pct) v[2*i +: 2] = 2'b10;
      else begin
        r = $urandom % 3;
        v[2*i +: 2] = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
      end
    end
    return v;
  endfunction

  // Called at a negedge: drive, take one edge, update the model, check outputs
  task automatic cycle(input logic m, input logic [2*K-1:0] c);
    logic changed;
    gen_sel = m; stage_codes = c;
    hist_mode[ec] = m; hist_code[ec] = c;
    changed = (ec == 0) ? (m != 1'b0) : (m != hist_mode[ec-1]);
    @(posedge clk);
    for (int i = 0; i < K; i++) if (c[2*i +: 2] == 2'b10) exp_err = 1'b1;
    if (!m) begin
      conv_run = (conv_run < K + 2) ? conv_run + 1 : K + 2;
      gen_run = 0;
    end else begin
      gen_run++;
      conv_run = 0;
    end
    @(negedge clk);
    if (!m && conv_run == K + 2) begin
      exp_valid = 1'b1; exp_data = conv_expect(ec);
      check(conv_bad(ec) ? "R8 convert data" : {ph, " convert data"}, 32'(out_data), 32'(exp_data));
    end else if (m && (gen_run % G == 0)) begin
      exp_valid = 1'b1; exp_data = gen_expect(ec);
      check(gen_bad(ec) ? "R8 random word" : "R5 random word", 32'(out_data), 32'(exp_data));
      check("R6 top line zero", 32'(out_data[K]), 32'd0);
    end else begin
      exp_valid = 1'b0;
      check("R10 hold", 32'(out_data), 32'(exp_data));
    end
    check(changed ? "R11 switch blank" : (m ? "R7 random valid" : "R4 convert valid"),
          32'(out_valid), 32'(exp_valid));
    check("R9 error flag", 32'(code_err), 32'(exp_err));
    ec++;
  endtask

  initial begin
    #(64'd20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic m;
    int len;
    void'($urandom(32'd4721));
    rst_n = 1'b0; gen_sel = 1'b0; stage_codes = {K{2'b11}};
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(out_valid), 32'd0);
    check("R1 reset data", 32'(out_data), 32'd0);
    check("R1 reset error", 32'(code_err), 32'd0);
    rst_n = 1'b1;
    // R1: first clocks after release run in convert mode with no result yet
    ph = "R2";
    repeat (K + 4) cycle(1'b0, {K{2'b11}});
    repeat (K + 4) cycle(1'b0, {K{2'b00}});
    repeat (K + 4) cycle(1'b0, {{(K-1){2'b00}}, 2'b11});
    repeat (K + 4) cycle(1'b0, {2'b11, {(K-1){2'b01}}});
    ph = "R3";
    repeat (200) cycle(1'b0, rand_codes(0));
    repeat (12) cycle(1'b1, {K{2'b01}});
    repeat (12) cycle(1'b1, {{(K-3){2'b00}}, {3{2'b01}}});
    m = 1'b1;
    for (int n = 0; n < 90; n++) begin
      m = ~m;
      len = ($urandom % 4 == 0) ? 1 + $urandom % 3 : 4 + $urandom % 22;
      repeat (len) cycle(m, rand_codes(0));
    end
    for (int n = 0; n < 20; n++) begin
      m = ~m;
      len = ($urandom % 4 == 0) ? 1 + $urandom % 3 : 4 + $urandom % 22;
      repeat (len) cycle(m, rand_codes(n == 0 ? 0 : 8));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule